// File: doc/BRIEF.md
# External Bus Power-On Reset and Clock Sequencer

This block brings up an external parallel expansion bus segment that hangs off a host bridge. After a one-cycle start request it steps the bridge's bus-control outputs through a fixed order. First the drivers for the segment's reset and clock lines are enabled, with the clock still stopped and reset still asserted. Then the segment clock is started. Reset is held for a programmable number of microseconds, then released. The internal bus arbiter is selected, and after a short settle time a done flag is raised.

Every delay is a whole number of microseconds. A prescaler turns the system clock into a microsecond tick, and the prescaler's length comes from the clock-frequency parameter. Start requests that arrive while the sequence is in flight have no effect. Once the sequence ends, the done flag stays set until the next start request, and that request runs the whole sequence again from its first step.

Top module: `bus_bringup_seq`

## Requirements
- R1: While the synchronous reset `rst` is high, and in the first cycle after it, every output is low. Both driver enables are off, the clock is stopped, `busRstN` is 0 (reset asserted), the internal arbiter is not selected and `seqDone` is 0.
- R2: A start pulse sampled at edge k while idle or done enables both drivers from edge k on. At that point `clkRun`, `busRstN`, `arbIntSel` and `seqDone` are all 0.
- R3: `clkRun` rises at edge k+1, and from then on both driver enables stay set.
- R4: `busRstN` stays 0 for exactly HOLD_US*C cycles after the clock starts, where C = CLK_HZ/1e6. It rises at edge k+1+HOLD_US*C.
- R5: When `busRstN` rises, the clock and both driver enables stay set and keep their values.
- R6: `arbIntSel` rises one cycle after reset release, at edge k+2+HOLD_US*C.
- R7: `seqDone` rises SETTLE_US*C cycles after the arbiter is selected, at edge k+2+(HOLD_US+SETTLE_US)*C.
- R8: A start pulse during any cycle of a running sequence changes neither the outputs nor the timing.
- R9: `seqDone` stays high without a start. A start while done restarts the sequence: at the next edge `seqDone`, `clkRun`, `busRstN` and `arbIntSel` drop while the drivers stay enabled.
- R10: The microsecond tick divides the system clock by C = CLK_HZ/1e6, so every delay is a whole multiple of C cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startPulse | input | 1 | One-cycle request to run the sequence |
| rstDrvEn | output | 1 | Output enable of the bus reset driver |
| clkDrvEn | output | 1 | Output enable of the bus clock driver |
| clkRun | output | 1 | Bus clock running |
| busRstN | output | 1 | Bus reset line, 0 = asserted |
| arbIntSel | output | 1 | Internal arbiter selected |
| seqDone | output | 1 | Sequence complete, held until next start |

## Verification
The bench sweeps a stray start pulse across every cycle of a running sequence. A design that restarted or retimed on such a pulse would show a late reset release or a late done flag. Each output is compared in every cycle against edge numbers worked out from the microsecond count, so an off-by-one in the prescaler or the microsecond counter shows up as a reset released one cycle or one microsecond early or late. Back-to-back runs check that done holds and that a restart returns clock and reset to their first-step values. A reset in mid-sequence checks that every line drops to its inactive value.

// File: rtl/bus_bringup_pkg.sv
package bus_bringup_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DRIVERS,
    ST_HOLD,
    ST_ARBWAIT,
    ST_SETTLE,
    ST_DONE
  } seqState_t;

  typedef enum logic {
    TMR_HOLD,
    TMR_SETTLE
  } timerSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic      enDrivers;
    logic      clkStart;
    logic      rstRelease;
    logic      arbSelect;
    logic      finish;
    logic      loadTimer;
    timerSel_t timerSel;
  } seqStrobes_t;

endpackage

// File: rtl/bus_bringup_datapath.sv
module bus_bringup_datapath
  import bus_bringup_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int HOLD_US   = 150,
  parameter int SETTLE_US = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  seqStrobes_t strobes,
  output logic        timerExpire,
  output logic        rstDrvEn,
  output logic        clkDrvEn,
  output logic        clkRun,
  output logic        busRstN,
  output logic        arbIntSel,
  output logic        seqDone
);

  localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
  localparam int PRE_W      = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam int US_MAX     = (HOLD_US > SETTLE_US) ? HOLD_US : SETTLE_US;
  localparam int US_W       = $clog2(US_MAX + 1);
  localparam logic [PRE_W-1:0] PRE_LAST   = PRE_W'(CYC_PER_US - 1);
  localparam logic [US_W-1:0]  HOLD_LOAD  = US_W'(HOLD_US - 1);
  localparam logic [US_W-1:0]  SETTLE_LOAD = US_W'(SETTLE_US - 1);

  logic [PRE_W-1:0] preCnt;
  logic [US_W-1:0]  usLeft;
  logic             timerRun;
  logic             usTick;

  // Microsecond prescaler: one tick every CYC_PER_US cycles of a running timer
  assign usTick      = timerRun && (preCnt == PRE_LAST);
  assign timerExpire = usTick && (usLeft == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt   <= '0;
      usLeft   <= '0;
      timerRun <= 1'b0;
    end else if (strobes.loadTimer) begin
      preCnt   <= '0;
      usLeft   <= (strobes.timerSel == TMR_HOLD) ? HOLD_LOAD : SETTLE_LOAD;
      timerRun <= 1'b1;
    end else if (timerRun) begin
      if (timerExpire) begin
        timerRun <= 1'b0;
        preCnt   <= '0;
      end else if (usTick) begin
        preCnt <= '0;
        usLeft <= usLeft - 1'b1;
      end else begin
        preCnt <= preCnt + 1'b1;
      end
    end
  end

  // Bus control output register
  always_ff @(posedge clk) begin
    if (rst) begin
      rstDrvEn  <= 1'b0;
      clkDrvEn  <= 1'b0;
      clkRun    <= 1'b0;
      busRstN   <= 1'b0;
      arbIntSel <= 1'b0;
      seqDone   <= 1'b0;
    end else begin
      if (strobes.enDrivers) begin
        rstDrvEn  <= 1'b1;
        clkDrvEn  <= 1'b1;
        clkRun    <= 1'b0;
        busRstN   <= 1'b0;
        arbIntSel <= 1'b0;
        seqDone   <= 1'b0;
      end
      if (strobes.clkStart)   clkRun    <= 1'b1;
      if (strobes.rstRelease) busRstN   <= 1'b1;
      if (strobes.arbSelect)  arbIntSel <= 1'b1;
      if (strobes.finish)     seqDone   <= 1'b1;
    end
  end

  p_tick_bound_r10: assert property (@(posedge clk) disable iff (rst)
    preCnt <= PRE_LAST);
  p_clk_needs_drv_r3: assert property (@(posedge clk) disable iff (rst)
    clkRun |-> (rstDrvEn && clkDrvEn));
  p_release_needs_clk_r5: assert property (@(posedge clk) disable iff (rst)
    busRstN |-> clkRun);
  p_release_holds_clk_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busRstN) |-> ($past(clkRun) && $stable(clkDrvEn) && $stable(rstDrvEn)));
  p_arb_after_release_r6: assert property (@(posedge clk) disable iff (rst)
    arbIntSel |-> busRstN);
  p_done_after_arb_r7: assert property (@(posedge clk) disable iff (rst)
    seqDone |-> arbIntSel);

endmodule

// File: rtl/bus_bringup_control.sv
module bus_bringup_control
  import bus_bringup_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startPulse,
  input  logic        timerExpire,
  output seqStrobes_t strobes
);

  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      ST_IDLE, ST_DONE: begin
        if (startPulse) begin
          strobes.enDrivers = 1'b1;
          stateNext         = ST_DRIVERS;
        end
      end
      ST_DRIVERS: begin
        strobes.clkStart  = 1'b1;
        strobes.loadTimer = 1'b1;
        strobes.timerSel  = TMR_HOLD;
        stateNext         = ST_HOLD;
      end
      ST_HOLD: begin
        if (timerExpire) begin
          strobes.rstRelease = 1'b1;
          stateNext          = ST_ARBWAIT;
        end
      end
      ST_ARBWAIT: begin
        strobes.arbSelect = 1'b1;
        strobes.loadTimer = 1'b1;
        strobes.timerSel  = TMR_SETTLE;
        stateNext         = ST_SETTLE;
      end
      ST_SETTLE: begin
        if (timerExpire) begin
          strobes.finish = 1'b1;
          stateNext      = ST_DONE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= stateNext;
  end

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (startPulse && state != ST_IDLE && state != ST_DONE) |=> state != ST_DRIVERS);
  p_one_strobe_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobes.enDrivers, strobes.clkStart, strobes.rstRelease,
              strobes.arbSelect, strobes.finish}));
  p_done_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !startPulse) |=> state == ST_DONE);

endmodule

// File: rtl/bus_bringup_seq.sv
module bus_bringup_seq
  import bus_bringup_pkg::*;
#(
  parameter int CLK_HZ    = 100_000_000,
  parameter int HOLD_US   = 150,
  parameter int SETTLE_US = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic startPulse,
  output logic rstDrvEn,
  output logic clkDrvEn,
  output logic clkRun,
  output logic busRstN,
  output logic arbIntSel,
  output logic seqDone
);

  seqStrobes_t strobes;
  logic        timerExpire;

  bus_bringup_control u_control (
    .clk         (clk),
    .rst         (rst),
    .startPulse  (startPulse),
    .timerExpire (timerExpire),
    .strobes     (strobes)
  );

  bus_bringup_datapath #(
    .CLK_HZ    (CLK_HZ),
    .HOLD_US   (HOLD_US),
    .SETTLE_US (SETTLE_US)
  ) u_datapath (
    .clk         (clk),
    .rst         (rst),
    .strobes     (strobes),
    .timerExpire (timerExpire),
    .rstDrvEn    (rstDrvEn),
    .clkDrvEn    (clkDrvEn),
    .clkRun      (clkRun),
    .busRstN     (busRstN),
    .arbIntSel   (arbIntSel),
    .seqDone     (seqDone)
  );

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> !(rstDrvEn || clkDrvEn || clkRun || busRstN || arbIntSel || seqDone));

endmodule

// File: tb/bus_bringup_seq_bench.sv
module bus_bringup_seq_bench;

  localparam int CLK_HZ    = 3_000_000;
  localparam int HOLD_US   = 4;
  localparam int SETTLE_US = 2;
  localparam int C         = CLK_HZ / 1_000_000;
  localparam int REL_AT    = 1 + HOLD_US * C;
  localparam int ARB_AT    = REL_AT + 1;
  localparam int DONE_AT   = ARB_AT + SETTLE_US * C;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startPulse = 1'b0;
  logic rstDrvEn, clkDrvEn, clkRun, busRstN, arbIntSel, seqDone;
  int   checks = 0;
  int   failures = 0;

  always #5 clk = ~clk;

  bus_bringup_seq #(
    .CLK_HZ(CLK_HZ), .HOLD_US(HOLD_US), .SETTLE_US(SETTLE_US)
  ) u_bus_bringup_seq (
    .clk(clk), .rst(rst), .startPulse(startPulse),
    .rstDrvEn(rstDrvEn), .clkDrvEn(clkDrvEn), .clkRun(clkRun),
    .busRstN(busRstN), .arbIntSel(arbIntSel), .seqDone(seqDone)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic checkQuiet(input string req);
    check(req, "rstDrvEn", rstDrvEn, 1'b0);
    check(req, "clkDrvEn", clkDrvEn, 1'b0);
    check(req, "clkRun", clkRun, 1'b0);
    check(req, "busRstN", busRstN, 1'b0);
    check(req, "arbIntSel", arbIntSel, 1'b0);
    check(req, "seqDone", seqDone, 1'b0);
  endtask

  // One run: start sampled at edge k; index c = edges since k. A stray start
  // goes in before edge k+strayAt (strayAt < 0 means none).
  task automatic runSeq(input int strayAt);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    for (int c = 0; c <= DONE_AT + 3; c++) begin
      // R2 drivers on from edge k; R3 clock one edge later; R4 hold length
      check("R2", "rstDrvEn", rstDrvEn, 1'b1);
      check("R3", "clkDrvEn", clkDrvEn, 1'b1);
      check("R3", "clkRun", clkRun, c >= 1);
      check((strayAt >= 0) ? "R8" : "R4", "busRstN", busRstN, c >= REL_AT);
      check("R6", "arbIntSel", arbIntSel, c >= ARB_AT);
      check((c > DONE_AT) ? "R9" : "R7", "seqDone", seqDone, c >= DONE_AT);
      if (c == REL_AT) check("R5", "clkRun at release", clkRun, 1'b1);
      startPulse = (c + 1 == strayAt);
      @(negedge clk);
    end
    startPulse = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        checkQuiet("R1");
        rst = 1'b0;
        @(negedge clk);
        checkQuiet("R1");
        // Idle with no start: nothing happens
        repeat (4) @(negedge clk);
        checkQuiet("R1");
        runSeq(-1);
        // Restart from done
        runSeq(-1);
        // R8 sweep of stray start over every cycle of a running sequence
        for (int s = 1; s < DONE_AT; s++) runSeq(s);
        // R10: clock count of hold window is a multiple of the prescale
        check("R10", "hold multiple of C", ((REL_AT - 1) % C) == 0, 1'b1);
        // R1 reset in mid-sequence
        startPulse = 1'b1;
        @(negedge clk);
        startPulse = 1'b0;
        repeat (REL_AT + 1) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        checkQuiet("R1");
        rst = 1'b0;
        repeat (2) @(negedge clk);
        checkQuiet("R1");
        runSeq(-1);
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule